// File: doc/BRIEF.md
# Program Fetch Source Selector

This block sits between a CPU core's instruction fetch port and the two places code can live: a small on-chip code ROM covering the bottom of a 64K code space, and an external code bus. While reset is held, it captures the level of an external-access strap pin. After reset, every fetch is routed by two inputs: that captured strap and whether the fetch address is below the 4K boundary.

Fetches served by the ROM return their byte one clock after the request is taken. Fetches sent to the external bus place the address on the bus and drive an active-low program-store strobe for a fixed window of three clocks. The returned byte is sampled in the last strobe clock. The core talks to the block through a request/ready/valid handshake, and only one fetch can be outstanding at a time.

Top module: `code_fetch_router`

## Requirements
- R1: After reset is released, and before any request, `code_strobe_n` is 1, `fetch_valid` is 0 and `fetch_ready` is 1.
- R2: `ext_strap` is sampled on every clock edge while `rst_n` is 0, and the last value sampled is held. Changes to `ext_strap` while `rst_n` is 1 do not change how fetches are routed.
- R3: With a captured strap of 0, every fetch address from 0000H to FFFFH is served externally.
- R4: With a captured strap of 1, addresses 0000H to 0FFFH are served by the ROM and `code_strobe_n` stays 1. With the default parameters, ROM byte(a) = a[7:0] ^ {a[11:8], a[11:8]} ^ 5AH.
- R5: Addresses 1000H and above are served externally whatever the captured strap.
- R6: For an external fetch, `code_strobe_n` is 0 for exactly 3 consecutive cycles, starting in the cycle after acceptance. `code_addr` equals the fetch address throughout. `fetch_data` is the `code_rdata` value present in the last strobe cycle, and `fetch_valid` rises in the cycle after that window (4 cycles after the accepting edge).
- R7: For an internal fetch, `fetch_valid` and `fetch_data` appear in the cycle right after the accepting clock edge.
- R8: A request is accepted when `fetch_req` and `fetch_ready` are both 1 at a clock edge. `fetch_valid` is 1 for exactly one cycle per accepted request. `fetch_ready` is 0 while an external fetch is outstanding, and requests made then are ignored: they cause no further strobe and no further valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; strap is sampled while low |
| ext_strap | input | 1 | External-access strap level |
| fetch_req | input | 1 | Fetch request from the core |
| fetch_addr | input | 16 | Code address of the fetch |
| fetch_ready | output | 1 | Block can accept a request this cycle |
| fetch_valid | output | 1 | One-cycle pulse: fetch_data holds the fetched byte |
| fetch_data | output | 8 | Fetched code byte |
| code_addr | output | 16 | Address on the external code bus |
| code_strobe_n | output | 1 | Active-low program-store strobe for external reads |
| code_rdata | input | 8 | Byte returned by external code memory |

## Verification
Two situations are hard to reach from the ports. The first is a strap change that comes after reset has been released. The bench flips `ext_strap` during operation and then fetches addresses whose routing would change if the strap were still being sampled. The second is a request that arrives while the block is busy. The bench keeps `fetch_req` high, pointed at a ROM address, through a whole external strobe window, then drops it on the valid cycle and checks that no second valid or strobe appears. The bench's external memory model returns a byte that differs from the ROM byte at every address, so the data alone shows which source served each fetch in the address sweeps.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
    localparam int CODE_AW       = 16;
    localparam int DATA_W        = 8;
    localparam int ROM_AW        = 12;
    localparam int STROBE_CYCLES = 3;

    typedef enum logic {
        SRC_INT = 1'b0,
        SRC_EXT = 1'b1
    } fetch_src_e;
endpackage

// File: rtl/fetch_strap_capture.sv
module fetch_strap_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic strap_in,
    output logic strap_hi
);
    typedef struct packed {
        logic strap;
    } strap_state_t;

    strap_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!rst_n) begin
            s_d.strap = strap_in;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign strap_hi = s_q.strap;

    // R2
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(strap_hi));
endmodule

// File: rtl/fetch_code_rom.sv
module fetch_code_rom #(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] data
);
    localparam int HI_W = 4;

    logic [HI_W-1:0] page;
    logic [7:0]      byte_val;

    always_comb begin
        page     = addr[AW-1 -: HI_W];
        byte_val = addr[7:0] ^ {page, page} ^ 8'h5A;
        data     = DW'(byte_val);
    end
endmodule

// File: rtl/fetch_ext_seq.sv
module fetch_ext_seq #(
    parameter int AW  = 16,
    parameter int STB = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    output logic          busy,
    output logic          last,
    output logic [AW-1:0] bus_addr,
    output logic          strobe_n
);
    localparam int CW = (STB > 1) ? $clog2(STB) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(STB - 1);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
        logic [AW-1:0] addr;
    } seq_state_t;

    seq_state_t s_d, s_q;

    assign last     = s_q.active && (s_q.cnt == LAST_CNT);
    assign busy     = s_q.active;
    assign bus_addr = s_q.addr;
    assign strobe_n = !s_q.active;

    always_comb begin
        s_d = s_q;
        if (start) begin
            s_d.active = 1'b1;
            s_d.cnt    = '0;
            s_d.addr   = start_addr;
        end else if (s_q.active) begin
            if (last) begin
                s_d.active = 1'b0;
                s_d.cnt    = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R8
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> strobe_n);

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_n && $past(!strobe_n)) |-> $stable(bus_addr));
endmodule

// File: rtl/code_fetch_router.sv
module code_fetch_router
    import fetch_pkg::*;
#(
    parameter int AW    = CODE_AW,
    parameter int DW    = DATA_W,
    parameter int ROM_W = ROM_AW,
    parameter int STB   = STROBE_CYCLES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_strap,
    input  logic          fetch_req,
    input  logic [AW-1:0] fetch_addr,
    output logic          fetch_ready,
    output logic          fetch_valid,
    output logic [DW-1:0] fetch_data,
    output logic [AW-1:0] code_addr,
    output logic          code_strobe_n,
    input  logic [DW-1:0] code_rdata
);
    localparam int HI_W = AW - ROM_W;

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
    } out_state_t;

    out_state_t r_d, r_q;

    logic          strap_hi;
    logic [DW-1:0] rom_data;
    logic          ext_busy;
    logic          ext_last;
    logic          accept;
    logic          ext_start;
    logic          low_page;
    fetch_src_e    src;

    fetch_strap_capture u_strap (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap_in (ext_strap),
        .strap_hi (strap_hi)
    );

    fetch_code_rom #(.AW(ROM_W), .DW(DW)) u_rom (
        .addr (fetch_addr[ROM_W-1:0]),
        .data (rom_data)
    );

    fetch_ext_seq #(.AW(AW), .STB(STB)) u_ext (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (ext_start),
        .start_addr (fetch_addr),
        .busy       (ext_busy),
        .last       (ext_last),
        .bus_addr   (code_addr),
        .strobe_n   (code_strobe_n)
    );

    always_comb begin
        low_page    = (fetch_addr[AW-1 -: HI_W] == '0);
        src         = (strap_hi && low_page) ? SRC_INT : SRC_EXT;
        fetch_ready = !ext_busy;
        accept      = fetch_req && fetch_ready;
        ext_start   = accept && (src == SRC_EXT);

        r_d       = r_q;
        r_d.valid = 1'b0;
        if (accept && (src == SRC_INT)) begin
            r_d.valid = 1'b1;
            r_d.data  = rom_data;
        end else if (ext_last) begin
            r_d.valid = 1'b1;
            r_d.data  = code_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign fetch_valid = r_q.valid;
    assign fetch_data  = r_q.data;

    // R4
    int_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && strap_hi && low_page) |=> (code_strobe_n && fetch_valid));

    // R5
    hi_addr_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !low_page) |=> !code_strobe_n);

    // R8
    valid_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> ($past(accept && src == SRC_INT) || $past(ext_last)));

    // R8
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !code_strobe_n |-> !fetch_ready);
endmodule

// File: tb/sim_code_fetch_router.sv
module sim_code_fetch_router;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_strap = 1'b0;
    logic        fetch_req = 1'b0;
    logic [15:0] fetch_addr = '0;
    logic        fetch_ready;
    logic        fetch_valid;
    logic [7:0]  fetch_data;
    logic [15:0] code_addr;
    logic        code_strobe_n;
    logic [7:0]  code_rdata;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] rom_f(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
    endfunction

    function automatic logic [7:0] ext_f(input logic [15:0] a);
        return ~a[7:0] ^ {4'h0, a[11:8]};
    endfunction

    assign code_rdata = ext_f(code_addr);

    code_fetch_router u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .ext_strap     (ext_strap),
        .fetch_req     (fetch_req),
        .fetch_addr    (fetch_addr),
        .fetch_ready   (fetch_ready),
        .fetch_valid   (fetch_valid),
        .fetch_data    (fetch_data),
        .code_addr     (code_addr),
        .code_strobe_n (code_strobe_n),
        .code_rdata    (code_rdata)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
        end
    endtask

    task automatic do_reset(input logic s);
        @(negedge clk);
        rst_n = 1'b0;
        ext_strap = s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 idle state after reset
        chk(code_strobe_n == 1'b1, "R1 strobe", int'(code_strobe_n), 1);
        chk(fetch_valid == 1'b0, "R1 valid", int'(fetch_valid), 0);
        chk(fetch_ready == 1'b1, "R1 ready", int'(fetch_ready), 1);
    endtask

    task automatic do_fetch(input logic [15:0] a, input bit exp_int, input string rq,
                            input bit hold_junk);
        int n;
        int low;
        int exp_lat;
        logic [7:0] exp_d;
        exp_lat = exp_int ? 1 : 4;
        exp_d   = exp_int ? rom_f(a) : ext_f(a);
        chk(fetch_ready == 1'b1, "R8 ready before req", int'(fetch_ready), 1);
        fetch_req  = 1'b1;
        fetch_addr = a;
        @(negedge clk);
        if (hold_junk) fetch_addr = 16'h0020;
        else fetch_req = 1'b0;
        n = 1;
        low = 0;
        while (1) begin
            if (!code_strobe_n) begin
                low++;
                // R6 address on the bus during strobe
                chk(code_addr == a, "R6 code_addr", int'(code_addr), int'(a));
            end
            if (fetch_valid || n > 20) break;
            n++;
            @(negedge clk);
        end
        fetch_req = 1'b0;
        chk(n == exp_lat, exp_int ? "R7 latency" : "R6 latency", n, exp_lat);
        chk(low == (exp_int ? 0 : 3), exp_int ? "R4 no strobe" : "R6 strobe width",
            low, exp_int ? 0 : 3);
        chk(fetch_data == exp_d, rq, int'(fetch_data), int'(exp_d));
        @(negedge clk);
        // R8 one valid per request
        chk(fetch_valid == 1'b0, "R8 single pulse", int'(fetch_valid), 0);
        if (hold_junk) begin
            @(negedge clk);
            chk(fetch_valid == 1'b0 && code_strobe_n == 1'b1, "R8 busy req ignored",
                int'({fetch_valid, code_strobe_n}), 1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog act=0 exp=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R3: strap low, sweep the whole space
        do_reset(1'b0);
        for (int a = 0; a < 65536; a += 331) begin
            do_fetch(16'(a), 1'b0, "R3 data", 1'b0);
        end
        for (int a = 16'h0FFC; a <= 16'h1003; a++) begin
            do_fetch(16'(a), 1'b0, "R3 boundary", 1'b0);
        end
        do_fetch(16'hFFFF, 1'b0, "R3 top", 1'b0);
        // R2: raising the strap after reset changes nothing
        ext_strap = 1'b1;
        @(negedge clk);
        do_fetch(16'h0010, 1'b0, "R2 late strap high", 1'b0);
        do_fetch(16'h0FFF, 1'b0, "R2 late strap high", 1'b0);

        // R4 and R5: strap high
        do_reset(1'b1);
        for (int a = 0; a < 65536; a += 331) begin
            if (a < 16'h1000) do_fetch(16'(a), 1'b1, "R4 data", 1'b0);
            else              do_fetch(16'(a), 1'b0, "R5 data", 1'b0);
        end
        for (int a = 16'h0FFC; a <= 16'h1003; a++) begin
            if (a < 16'h1000) do_fetch(16'(a), 1'b1, "R4 boundary", 1'b0);
            else              do_fetch(16'(a), 1'b0, "R5 boundary", 1'b0);
        end
        do_fetch(16'h0000, 1'b1, "R4 bottom", 1'b0);
        do_fetch(16'hFFFF, 1'b0, "R5 top", 1'b0);
        // R8: request held during an external fetch is ignored
        do_fetch(16'h2345, 1'b0, "R8 held req data", 1'b1);
        do_fetch(16'hC000, 1'b0, "R8 held req data", 1'b1);
        // R2: dropping the strap after reset changes nothing
        ext_strap = 1'b0;
        @(negedge clk);
        do_fetch(16'h0123, 1'b1, "R2 late strap low", 1'b0);
        do_fetch(16'h0ABC, 1'b1, "R2 late strap low", 1'b0);

        // R2: last level sampled during reset wins
        @(negedge clk);
        rst_n = 1'b0;
        ext_strap = 1'b1;
        @(negedge clk);
        ext_strap = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        ext_strap = 1'b1;
        @(negedge clk);
        do_fetch(16'h0456, 1'b0, "R2 last reset sample", 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule